// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Set-Associative Lookaside Buffer

This block turns a 14-bit virtual address into a 12-bit physical address. Pages are 64 bytes, so the low six address bits pass straight through and only the upper eight bits, the virtual page number, are translated. A translation first searches a small 16-entry lookaside buffer, built as four sets of four ways. If that search finds no entry, the block reads a 256-entry single-level page table held in registers.

A request is one cycle of `req_valid` with an address. A hit returns its result on the next cycle. A miss spends one extra cycle reading the page table and then returns its result. The result is either a physical address or a page fault. A miss whose page-table entry is valid also installs that mapping in the lookaside buffer. A single write port fills both the page table and the lookaside buffer, and a synchronous reset clears every valid bit. A caller issues a new request only after `done` has returned for the previous one.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address is {physical page number, virtual address bits 5:0}. The low six bits are never altered.
- R2: The lookaside buffer set is selected by virtual address bits 7:6 and the tag is bits 13:8. A hit needs a valid way in that set whose tag matches. A hit raises `done` and `hit` one cycle after the request and gives the stored page number.
- R3: On a miss, `done` rises two cycles after the request with `hit`=0. The result comes from the page-table entry indexed by the full 8-bit page number.
- R4: On a miss whose page-table entry is invalid, `fault`=1 with `done` and `paddr`=0. Nothing is installed, so a repeated request misses again.
- R5: A miss with a valid page-table entry installs the mapping into the lowest-numbered invalid way of the selected set.
- R6: When all four ways of the set are valid, the way replaced is the one named by that set's round-robin pointer. The pointer starts at 0 and steps by one, wrapping, on each such replacement.
- R7: Write port encoding: `wr_sel`=0 writes page-table entry `wr_vpn`. `wr_sel`=1 writes way `wr_way` of set `wr_vpn[1:0]`, with tag `wr_vpn[7:2]`. Both writes store `wr_ppn` and `wr_valid`. A valid buffer entry takes precedence over the page table.
- R8: Synchronous reset clears all buffer and page-table valid bits and the pointers, and drives `done`, `hit`, `fault` and `paddr` to 0.
- R9: `done` is a one-cycle pulse. `hit` and `fault` are only high together with `done`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address of the request |
| wr_en | input | 1 | Write port strobe |
| wr_sel | input | 1 | 0 = page table, 1 = lookaside buffer |
| wr_vpn | input | 8 | Page number addressed by the write |
| wr_way | input | 2 | Buffer way written when wr_sel=1 |
| wr_ppn | input | 6 | Physical page number written |
| wr_valid | input | 1 | Valid bit written |
| done | output | 1 | Result pulse |
| hit | output | 1 | Result came from the lookaside buffer |
| fault | output | 1 | Page fault |
| paddr | output | 12 | Physical address |

## Verification
The bench builds the block with its default parameters: 14-bit virtual and 12-bit physical addresses, 64-byte pages, and four sets of four ways. With four ways, a fifth page number that maps to set 3 fills that set and forces replacement. A stepped series of such misses shows that the pointer advances through ways 0, 1 and 2. The same sequence also exercises the fill-first-invalid order, repeated faults on an unmapped page, a buffer entry with no matching page-table entry, and the clearing of all state by reset.

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [VA_W-OFF_W-1:0]     wr_vpn,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [PA_W-OFF_W-1:0]     wr_ppn,
  input  logic                      wr_valid,
  output logic                      done,
  output logic                      hit,
  output logic                      fault,
  output logic [PA_W-1:0]           paddr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PT_N  = 1 << VPN_W;

  logic [TAG_W-1:0] t_tag [SETS][WAYS];
  logic [PPN_W-1:0] t_ppn [SETS][WAYS];
  logic [WAYS-1:0]  t_vld [SETS];
  logic [WAY_W-1:0] rr    [SETS];
  logic [PPN_W-1:0] pt_ppn [PT_N];
  logic [PT_N-1:0]  pt_vld;

  logic            walking;
  logic [VA_W-1:0] held_va;

  wire [VPN_W-1:0] q_vpn = req_vaddr[VA_W-1:OFF_W];
  wire [IDX_W-1:0] q_set = q_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag = q_vpn[VPN_W-1:IDX_W];
  wire [VPN_W-1:0] h_vpn = held_va[VA_W-1:OFF_W];
  wire [IDX_W-1:0] h_set = h_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] h_tag = h_vpn[VPN_W-1:IDX_W];
  wire [PPN_W-1:0] pe_ppn = pt_ppn[h_vpn];
  wire             pe_vld = pt_vld[h_vpn];

  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++)
      if (t_vld[q_set][w] && t_tag[q_set][w] == q_tag) begin
        lk_hit = 1'b1;
        lk_ppn = t_ppn[q_set][w];
      end
  end

  logic [WAY_W-1:0] vic;
  logic             vic_free;
  always_comb begin
    vic      = rr[h_set];
    vic_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!t_vld[h_set][w]) begin
        vic      = WAY_W'(w);
        vic_free = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      walking <= 1'b0;
      done    <= 1'b0;
      hit     <= 1'b0;
      fault   <= 1'b0;
      paddr   <= '0;
      pt_vld  <= '0;
      for (int s = 0; s < SETS; s++) begin
        t_vld[s] <= '0;
        rr[s]    <= '0;
      end
    end else begin
      done  <= 1'b0;
      hit   <= 1'b0;
      fault <= 1'b0;
      if (wr_en) begin
        if (wr_sel) begin
          t_tag[wr_vpn[IDX_W-1:0]][wr_way] <= wr_vpn[VPN_W-1:IDX_W];
          t_ppn[wr_vpn[IDX_W-1:0]][wr_way] <= wr_ppn;
          t_vld[wr_vpn[IDX_W-1:0]][wr_way] <= wr_valid;
        end else begin
          pt_ppn[wr_vpn] <= wr_ppn;
          pt_vld[wr_vpn] <= wr_valid;
        end
      end
      if (walking) begin
        walking <= 1'b0;
        done    <= 1'b1;
        fault   <= !pe_vld;
        paddr   <= pe_vld ? {pe_ppn, held_va[OFF_W-1:0]} : '0;
        if (pe_vld) begin
          t_tag[h_set][vic] <= h_tag;
          t_ppn[h_set][vic] <= pe_ppn;
          t_vld[h_set][vic] <= 1'b1;
          if (!vic_free) rr[h_set] <= rr[h_set] + 1'b1;
        end
      end else if (req_valid) begin
        if (lk_hit) begin
          done  <= 1'b1;
          hit   <= 1'b1;
          paddr <= {lk_ppn, req_vaddr[OFF_W-1:0]};
        end else begin
          walking <= 1'b1;
          held_va <= req_vaddr;
        end
      end
    end
  end
endmodule

module tlb_xlate_chk #(
  parameter int PA_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            done,
  input logic            hit,
  input logic            fault,
  input logic [PA_W-1:0] paddr
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_flags_need_done_r9: assert property (@(posedge clk) disable iff (rst) (hit || fault) |-> done);
  p_hit_xor_fault_r9: assert property (@(posedge clk) disable iff (rst) !(hit && fault));
  p_hit_one_cycle_r2: assert property (@(posedge clk) disable iff (rst) $rose(hit) |-> $past(req_valid));
  p_fault_zero_addr_r4: assert property (@(posedge clk) disable iff (rst) fault |-> paddr == '0);
  p_reset_clears_r8: assert property (@(posedge clk) $past(rst) |-> !done && !hit && !fault && paddr == '0);
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .done(done),
  .hit(hit), .fault(fault), .paddr(paddr)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_valid = 1'b0;
  logic [7:0]  wr_vpn = '0;
  logic [1:0]  wr_way = '0;
  logic [5:0]  wr_ppn = '0;
  logic        done, hit, fault;
  logic [11:0] paddr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_vpn(wr_vpn), .wr_way(wr_way),
    .wr_ppn(wr_ppn), .wr_valid(wr_valid),
    .done(done), .hit(hit), .fault(fault), .paddr(paddr)
  );

  // {vaddr, hit, fault, paddr}
  localparam logic [27:0] VEC [14] = '{
    {14'h03D4, 1'b0, 1'b0, 12'h354},  // R3 first access misses
    {14'h03D4, 1'b1, 1'b0, 12'h354},  // R2 refilled entry hits
    {14'h0020, 1'b0, 1'b0, 12'hA20},  // R3
    {14'h0025, 1'b1, 1'b0, 12'hA25},  // R1 offset passes through
    {14'h0100, 1'b0, 1'b1, 12'h000},  // R4 fault
    {14'h0100, 1'b0, 1'b1, 12'h000},  // R4 no refill
    {14'h00C0, 1'b0, 1'b0, 12'h080},  // R5 set 3 way 1
    {14'h01C0, 1'b0, 1'b0, 12'h440},  // R5 way 2
    {14'h02C0, 1'b0, 1'b0, 12'hFC0},  // R5 way 3
    {14'h04C0, 1'b0, 1'b0, 12'hA80},  // R6 evicts way 0 (page 0x0F)
    {14'h03C0, 1'b0, 1'b0, 12'h340},  // R6 evicts way 1 (page 0x03)
    {14'h01C7, 1'b1, 1'b0, 12'h447},  // R6 page 0x07 still present
    {14'h00C1, 1'b0, 1'b0, 12'h081},  // R6 page 0x03 was evicted
    {14'h04C0, 1'b1, 1'b0, 12'hA80}   // R6 page 0x13 kept
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] vpn, input logic [1:0] way,
                    input logic [5:0] ppn, input bit vld);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_vpn = vpn; wr_way = way; wr_ppn = ppn; wr_valid = vld;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xlate(input logic [13:0] va, input bit e_hit, input bit e_fault,
                       input logic [11:0] e_pa, input string req);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == (e_hit ? 1 : 2), {req, " latency"}, lat, e_hit ? 1 : 2);
    check(hit == e_hit, {req, " hit"}, hit, e_hit);
    check(fault == e_fault, {req, " fault"}, fault, e_fault);
    check(paddr == e_pa, {req, " paddr"}, paddr, e_pa);
    @(negedge clk);
    check(!done, "R9 done pulse", done, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !hit && !fault && paddr == 0, "R8 reset outputs",
          {done, hit, fault, paddr}, 0);

    wr(1'b0, 8'h0F, 2'd0, 6'h0D, 1'b1);
    wr(1'b0, 8'h00, 2'd0, 6'h28, 1'b1);
    wr(1'b0, 8'h04, 2'd0, 6'h11, 1'b0);
    wr(1'b0, 8'h03, 2'd0, 6'h02, 1'b1);
    wr(1'b0, 8'h07, 2'd0, 6'h11, 1'b1);
    wr(1'b0, 8'h0B, 2'd0, 6'h3F, 1'b1);
    wr(1'b0, 8'h13, 2'd0, 6'h2A, 1'b1);

    for (int i = 0; i < 14; i++)
      xlate(VEC[i][27:14], VEC[i][13], VEC[i][12], VEC[i][11:0], "R1-vector");

    // R7: buffer entry with no page-table mapping for page 0x21 (set 1)
    wr(1'b1, 8'h21, 2'd2, 6'h05, 1'b1);
    xlate(14'h0845, 1'b1, 1'b0, 12'h145, "R7 buffer write");
    // R7: clearing page-table entry 0x00 leaves buffered mapping intact
    wr(1'b0, 8'h00, 2'd0, 6'h00, 1'b0);
    xlate(14'h0020, 1'b1, 1'b0, 12'hA20, "R7 buffer precedence");

    // R8: reset clears valid bits, so 0x03D4 now faults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!done && paddr == 0, "R8 reset after use", paddr, 0);
    xlate(14'h03D4, 1'b0, 1'b1, 12'h000, "R8 valid bits cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule